// File: doc/BRIEF.md
# Configurable Aspect-Ratio Dual-Port RAM

This block is a simple dual-port memory with one write port and one read port, each on its own clock. Its 1152 bits of storage are held as 64 physical rows of 18 bits. A static 2-bit shape input presents that storage as one of four logical arrays: 64 words of 18 bits, 128 of 9, 256 of 4 or 512 of 2. In the narrower shapes the low address bits pick a lane inside a row, and the upper address bits pick the row.

A write changes only the lane it addresses. It takes its data from the low bits of the write data bus. A read returns the addressed lane right-aligned, with every bit above the active width driven to zero. A second static input picks how reads are timed. In one setting the output is a register that loads on the read clock when read enable is high. In the other setting the output follows the read address with no clock.

Top module: `ratio_dpram`

## Requirements
- R1: The shape input selects the logical array: 2'b00 gives 64x18, 2'b01 gives 128x9, 2'b10 gives 256x4 and 2'b11 gives 512x2. A word written at an address in a shape reads back at the same address in that shape.
- R2: With shape code s, the physical row is address bits [s+5:s] and the lane is the low s address bits. Lane k of width W occupies row bits [k*W+W-1:k*W]. The 4-bit and 2-bit shapes use only row bits 15:0.
- R3: A write stores only the low W bits of the write data, where W is the active width (18, 9, 4 or 2). Write data bits above W have no effect.
- R4: A write leaves every bit of the row outside the addressed lane unchanged. This includes bits 17:16 in the 4-bit and 2-bit shapes.
- R5: Read data is the addressed lane shifted down to bit 0, with all bits at and above W reading as zero.
- R6: With the read timing input low, read data loads on a read clock edge while read enable is high and holds its value on edges where read enable is low.
- R7: With the read timing input high, read data follows the read address and stored contents with no clock edge, and read enable has no effect.
- R8: In registered read, a read and a write to the same location on the same clock edge return the data held before that write.
- R9: Address bits above the active depth are ignored: 2'b00 ignores bits 8:6, 2'b01 ignores bits 8:7 and 2'b10 ignores bit 8.
- R10: While the synchronous active-high read reset is high at a read clock edge, the registered read data is cleared to zero.
- R11: A write clock edge with write enable low changes no stored bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write port clock |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 9 | Write word address |
| wr_data | input | 18 | Write data, low bits used |
| rd_clk | input | 1 | Read port clock |
| rd_rst | input | 1 | Synchronous active-high reset of the read register |
| rd_en | input | 1 | Read enable for registered read |
| rd_addr | input | 9 | Read word address |
| rd_data | output | 18 | Right-aligned read data |
| async_rd | input | 1 | 1 selects unclocked read, 0 selects registered read |
| shape | input | 2 | Logical array shape code |

## Verification
The bench builds the block with its default parameters: 64 rows, 18-bit rows and a maximum lane-select shift of 3. These values give the full 9-bit address and all four shapes. They also give lane offsets of 9, 12 and 14 and the unused row bits 17:16 in the narrow shapes. Because of this, rows written in one shape can be read back in another, which checks the lane placement and the masking bit by bit. The 9-bit address is wider than the 6-bit row index. This makes the ignored upper address bits reachable in the wide shapes, where one address can alias another.

// File: rtl/ratio_dpram_pkg.sv
package ratio_dpram_pkg;

  typedef enum logic [1:0] {
    SHAPE_D64_W18  = 2'b00,
    SHAPE_D128_W9  = 2'b01,
    SHAPE_D256_W4  = 2'b10,
    SHAPE_D512_W2  = 2'b11
  } shape_e;

  // Lane width for a shape: the row width halved once per shape step.
  function automatic int unsigned lane_width(int unsigned row_w, logic [1:0] s);
    return row_w >> s;
  endfunction

endpackage

// File: rtl/ratio_dpram_addr_map.sv
module ratio_dpram_addr_map #(
  parameter int ROWS      = 64,
  parameter int ROW_W     = 18,
  parameter int MAX_SHIFT = 3,
  localparam int ROW_IW   = $clog2(ROWS),
  localparam int ADDR_W   = ROW_IW + MAX_SHIFT,
  localparam int OFF_W    = $clog2(ROW_W)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        shape,
  output logic [ROW_IW-1:0] row,
  output logic [OFF_W-1:0]  offset,
  output logic [OFF_W-1:0]  lane_w
);
  import ratio_dpram_pkg::*;

  localparam int LANE_IW = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

  logic [ADDR_W-1:0]  shifted;
  logic [ADDR_W-1:0]  lane_full;
  logic [LANE_IW-1:0] lane;

  always_comb begin
    shifted   = addr >> shape;
    row       = shifted[ROW_IW-1:0];
    lane_full = addr & ~({ADDR_W{1'b1}} << shape);
    lane      = lane_full[LANE_IW-1:0];
    lane_w    = OFF_W'(lane_width(ROW_W, shape));
    offset    = OFF_W'(lane) * lane_w;
  end

  // A lane must always sit inside its physical row (R2).
  always_comb begin
    if (!$isunknown({addr, shape})) begin
      assert_lane_in_row_R2: assert ((32'(offset) + 32'(lane_w)) <= 32'(ROW_W))
        else $error("lane overruns row: offset=%0d width=%0d", offset, lane_w);
    end
  end

endmodule

// File: rtl/ratio_dpram_lane_mask.sv
module ratio_dpram_lane_mask #(
  parameter int ROW_W  = 18,
  localparam int OFF_W = $clog2(ROW_W)
) (
  input  logic [OFF_W-1:0] offset,
  input  logic [OFF_W-1:0] lane_w,
  input  logic [ROW_W-1:0] data_in,
  output logic [ROW_W-1:0] bit_mask,
  output logic [ROW_W-1:0] data_pos
);
  logic [ROW_W-1:0] width_mask;

  always_comb begin
    width_mask = ~({ROW_W{1'b1}} << lane_w);
    bit_mask   = width_mask << offset;
    data_pos   = (data_in & width_mask) << offset;
  end

endmodule

// File: rtl/ratio_dpram_rd_align.sv
module ratio_dpram_rd_align #(
  parameter int ROW_W  = 18,
  localparam int OFF_W = $clog2(ROW_W)
) (
  input  logic [OFF_W-1:0] offset,
  input  logic [OFF_W-1:0] lane_w,
  input  logic [ROW_W-1:0] row_data,
  output logic [ROW_W-1:0] aligned
);
  logic [ROW_W-1:0] width_mask;

  always_comb begin
    width_mask = ~({ROW_W{1'b1}} << lane_w);
    aligned    = (row_data >> offset) & width_mask;
  end

endmodule

// File: rtl/ratio_dpram.sv
module ratio_dpram #(
  parameter int ROWS      = 64,
  parameter int ROW_W     = 18,
  parameter int MAX_SHIFT = 3,
  parameter int ADDR_W    = $clog2(ROWS) + MAX_SHIFT
) (
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ROW_W-1:0]  wr_data,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [ROW_W-1:0]  rd_data,
  input  logic              async_rd,
  input  logic [1:0]        shape
);
  localparam int ROW_IW = $clog2(ROWS);
  localparam int OFF_W  = $clog2(ROW_W);

  logic [ROW_W-1:0]  mem [ROWS];

  logic [ROW_IW-1:0] wr_row, rd_row;
  logic [OFF_W-1:0]  wr_off, wr_lane_w, rd_off, rd_lane_w;
  logic [ROW_W-1:0]  wr_mask, wr_pos;
  logic [ROW_W-1:0]  rd_row_data, rd_aligned, rd_q;

  ratio_dpram_addr_map #(.ROWS(ROWS), .ROW_W(ROW_W), .MAX_SHIFT(MAX_SHIFT)) u_wr_map (
    .addr(wr_addr), .shape(shape), .row(wr_row), .offset(wr_off), .lane_w(wr_lane_w)
  );

  ratio_dpram_addr_map #(.ROWS(ROWS), .ROW_W(ROW_W), .MAX_SHIFT(MAX_SHIFT)) u_rd_map (
    .addr(rd_addr), .shape(shape), .row(rd_row), .offset(rd_off), .lane_w(rd_lane_w)
  );

  ratio_dpram_lane_mask #(.ROW_W(ROW_W)) u_wr_lane (
    .offset(wr_off), .lane_w(wr_lane_w), .data_in(wr_data),
    .bit_mask(wr_mask), .data_pos(wr_pos)
  );

  // Bit-enable write: each row bit is written only when its mask bit is set.
  always_ff @(posedge wr_clk) begin
    if (wr_en) begin
      for (int b = 0; b < ROW_W; b++) begin
        if (wr_mask[b]) mem[wr_row][b] <= wr_pos[b];
      end
    end
  end

  assign rd_row_data = mem[rd_row];

  ratio_dpram_rd_align #(.ROW_W(ROW_W)) u_rd_align (
    .offset(rd_off), .lane_w(rd_lane_w), .row_data(rd_row_data), .aligned(rd_aligned)
  );

  always_ff @(posedge rd_clk) begin
    if (rd_rst)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_aligned;
  end

  assign rd_data = async_rd ? rd_aligned : rd_q;

  // A write touches exactly as many bits as the active width (R4).
  assert_wr_mask_width_R4: assert property (@(posedge wr_clk) disable iff (rd_rst)
    wr_en |-> ($countones(wr_mask) == 32'(wr_lane_w)))
    else $error("write mask width mismatch");

  // Registered read data holds while read enable is low (R6).
  assert_rd_hold_R6: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !rd_en |=> $stable(rd_q))
    else $error("read register changed without read enable");

  // Aligned data carries nothing above the active width (R5).
  assert_rd_upper_zero_R5: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !$isunknown(rd_aligned) |-> ((rd_aligned >> rd_lane_w) == '0))
    else $error("read data has bits above lane width");

endmodule

// File: tb/ratio_dpram_bench.sv
`timescale 1ns/1ps
module ratio_dpram_bench;

  typedef struct packed {
    logic [1:0]  shp;
    logic [8:0]  addr;
    logic [17:0] wdata;
    logic [17:0] expd;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{2'b00, 9'h005, 18'h2A5A5, 18'h2A5A5},
    '{2'b00, 9'h03F, 18'h1C3C3, 18'h1C3C3},
    '{2'b01, 9'h07F, 18'h3FFFF, 18'h001FF},
    '{2'b01, 9'h010, 18'h00155, 18'h00155},
    '{2'b10, 9'h0AB, 18'h3FFF9, 18'h00009},
    '{2'b11, 9'h1FF, 18'h3FFFE, 18'h00002},
    '{2'b11, 9'h000, 18'h00001, 18'h00001}
  };

  logic        clk = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, rd_rst = 1'b1, async_rd = 1'b0;
  logic [8:0]  wr_addr = '0, rd_addr = '0;
  logic [17:0] wr_data = '0;
  logic [17:0] rd_data;
  logic [1:0]  shape = 2'b00;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ratio_dpram u_ratio_dpram (
    .wr_clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_clk(clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .async_rd(async_rd), .shape(shape)
  );

  task automatic check(string req, logic [17:0] act, logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%05h expected=%05h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [8:0] a, logic [17:0] d);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(logic [8:0] a, output logic [17:0] q);
    @(negedge clk);
    rd_addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    q = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [17:0] q;
    repeat (3) @(negedge clk);
    check("R10 reset clears read data", rd_data, 18'h0);
    rd_rst = 1'b0;

    // Vector table: write then read back in each shape (R1, R3, R5).
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk); shape = VECS[i].shp;
      do_write(VECS[i].addr, VECS[i].wdata);
      do_read(VECS[i].addr, q);
      check($sformatf("R1/R3/R5 vector %0d", i), q, VECS[i].expd);
    end

    // Lane placement and isolation across shapes (R2, R4).
    @(negedge clk); shape = 2'b00;
    do_write(9'd3, 18'h00000);
    @(negedge clk); shape = 2'b11;
    do_write(9'd24, 18'h3FFFF);
    do_write(9'd31, 18'h00002);
    @(negedge clk); shape = 2'b00;
    do_read(9'd3, q);  check("R2 R4 2-bit lanes 0 and 7 in row", q, 18'h08003);
    @(negedge clk); shape = 2'b01;
    do_read(9'd7, q);  check("R2 9-bit upper lane", q, 18'h00040);
    @(negedge clk); shape = 2'b10;
    do_read(9'd15, q); check("R2 4-bit lane 3", q, 18'h00008);
    do_read(9'd12, q); check("R2 4-bit lane 0", q, 18'h00003);

    @(negedge clk); shape = 2'b00;
    do_write(9'd4, 18'h3FFFF);
    @(negedge clk); shape = 2'b10;
    do_write(9'd16, 18'h00000);
    do_write(9'd19, 18'h00000);
    @(negedge clk); shape = 2'b00;
    do_read(9'd4, q);  check("R4 bits 17:16 and other lanes kept", q, 18'h30FF0);

    // Upper address bits ignored (R9).
    do_write(9'h1C5, 18'h12345);
    do_read(9'h005, q); check("R9 alias of row 5", q, 18'h12345);

    // Write enable low changes nothing (R11).
    @(negedge clk);
    wr_addr = 9'd5; wr_data = 18'h00000; wr_en = 1'b0;
    @(negedge clk);
    do_read(9'd5, q); check("R11 disabled write", q, 18'h12345);

    // Hold without read enable (R6).
    @(negedge clk); rd_addr = 9'd3; rd_en = 1'b0;
    @(negedge clk);
    check("R6 hold while read enable low", rd_data, 18'h12345);

    // Unclocked read (R7).
    #1 async_rd = 1'b1;
    #1 check("R7 follows address 3", rd_data, 18'h08003);
    rd_addr = 9'd4;
    #1 check("R7 follows address 4 without edge", rd_data, 18'h30FF0);
    @(negedge clk); async_rd = 1'b0;

    // Same-edge read and write returns old data (R8).
    @(negedge clk);
    wr_addr = 9'd5; wr_data = 18'h00ABC; wr_en = 1'b1;
    rd_addr = 9'd5; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R8 collision returns old data", rd_data, 18'h12345);
    do_read(9'd5, q); check("R8 new data after collision", q, 18'h00ABC);

    // Reset clears a loaded register (R10).
    @(negedge clk); rd_rst = 1'b1;
    @(negedge clk); rd_rst = 1'b0;
    check("R10 reset after load", rd_data, 18'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule